// File: doc/BRIEF.md
# Slave PCM Codec Serial Transmitter

This block is a transmit-only serial PCM port. An external codec supplies both the bit clock and the frame sync. For every frame, the block sends one 10-bit audio sample, MSB first, on a single data line. The sample sits left-justified in a slot of 13 or 16 bits, and the unused low bits are sent as zeros. Outside its slot the block releases the line: the output enable is low and the data pin is held at zero.

The block runs on its own system clock, which must be much faster than the bit clock. It oversamples the bit clock and the frame sync through synchronizer stages and acts on their edges. Samples arrive through a valid/ready handshake into a one-entry holding register. A slot in progress shifts from a separate register, so a new sample cannot disturb the bits already on the line. If no fresh sample is waiting when a frame starts, the previous sample is sent again. Two static inputs select the slot length and whether the sync is short-frame (a one-bit pulse) or long-frame (a level that frames the slot).

Top module: `pcm_slave_tx`

## Requirements
- R1: After reset, `dx_oe_o` is 0, `dx_o` is 0 and `s_ready_o` is 1.
- R2: With `cfg_long_i`=0 (short-frame), the slot starts when the sync is seen high at a bit-clock falling edge. The MSB is driven from the next bit-clock rising edge, and each later rising edge moves to the next bit.
- R3: With `cfg_long_i`=1 (long-frame), the MSB is driven from the rising edge of the sync. Each following bit-clock rising edge moves to the next bit.
- R4: Slot bits 0..9 carry sample bits 9..0. They are followed by 3 zero bits when `cfg_slot16_i`=0 (13-bit slot) or 6 zero bits when `cfg_slot16_i`=1 (16-bit slot).
- R5: `dx_oe_o` falls at the bit-clock rising edge that follows the last padding bit, whatever level the sync has at that time.
- R6: Whenever `dx_oe_o` is 0, `dx_o` is 0.
- R7: A sample is accepted on a cycle where `s_valid_i` and `s_ready_o` are both 1. `s_ready_o` stays 0 while an accepted sample has not yet been sent, and a sample offered during that time is not taken.
- R8: A frame that starts with no accepted sample waiting sends the same sample as the previous frame.
- R9: A sample accepted while a slot is being sent does not change that slot. It is sent in the next frame.
- R10: The slot length is fixed when the slot starts. A change of `cfg_slot16_i` during a slot takes effect only from the next slot.
- R11: A sync rising edge that arrives while a slot is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Bit clock from the external codec |
| fsync_i | input | 1 | Frame sync from the external codec |
| cfg_long_i | input | 1 | 1: long-frame sync, 0: short-frame sync |
| cfg_slot16_i | input | 1 | 1: 16-bit slot, 0: 13-bit slot |
| s_valid_i | input | 1 | Sample offered |
| s_data_i | input | 10 | Sample value |
| s_ready_o | output | 1 | Holding register empty, sample can be taken |
| dx_o | output | 1 | Serial data, zero when not enabled |
| dx_oe_o | output | 1 | Data line enable, high only during the slot |

## Verification
The assertions assume three things about the inputs. Each bit-clock level lasts longer than the synchronizer depth plus one system cycle. The sync changes only together with a bit-clock rising edge. `cfg_long_i` does not change while a slot is in progress. The stimulus meets all three. The bit clock has a period of eight system cycles. The sync is updated only in the cycle where the bit clock rises. The sync format is chosen only between frames, while the line is idle. The one exception is a deliberate flip of the slot-length input in the middle of a slot, which is how the latching of the slot length is tested.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int unsigned SAMPLE_W_DEF  = 10;
  localparam int unsigned SLOT_SHORT_DEF = 13;
  localparam int unsigned SLOT_LONG_DEF  = 16;
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  typedef enum logic {
    FMT_SHORT = 1'b0,
    FMT_LONG  = 1'b1
  } sync_fmt_e;
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign prev_o  = prev_q;
endmodule

// File: rtl/pcm_sample_buf.sv
module pcm_sample_buf #(
  parameter int unsigned SAMPLE_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                s_valid_i,
  input  logic [SAMPLE_W-1:0] s_data_i,
  output logic                s_ready_o,
  input  logic                take_i,
  output logic [SAMPLE_W-1:0] next_o
);
  logic [SAMPLE_W-1:0] hold_q, last_q;
  logic                full_q;
  logic                accept;

  assign s_ready_o = ~full_q;
  assign accept    = s_valid_i & ~full_q;
  assign next_o    = full_q ? hold_q : last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      last_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (take_i) begin
        last_q <= next_o;
        if (full_q) full_q <= 1'b0;
      end
      if (accept) begin
        hold_q <= s_data_i;
        full_q <= 1'b1;
      end
    end
  end

  // R7: an accepted sample blocks further input until it is sent
  a_r7_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o) |=> !s_ready_o);

  // R9: a waiting sample is never overwritten
  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s_ready_o && !take_i) |=> $stable(hold_q));
endmodule

// File: rtl/pcm_frame_ctrl.sv
module pcm_frame_ctrl
  import pcm_tx_pkg::*;
#(
  parameter int unsigned SLOT_SHORT = 13,
  parameter int unsigned SLOT_LONG  = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bclk_rise_i,
  input  logic      bclk_fall_i,
  input  logic      fs_level_i,
  input  logic      fs_rise_i,
  input  sync_fmt_e fmt_i,
  input  logic      slot16_i,
  output logic      start_o,
  output logic      shift_o,
  output logic      end_o,
  output logic      active_o
);
  localparam int unsigned CNT_W = $clog2(SLOT_LONG);

  logic             active_q, armed_q;
  logic [CNT_W-1:0] cnt_q, last_q;
  logic             at_last;

  assign at_last = (cnt_q == last_q);
  assign start_o = ~active_q & ((fmt_i == FMT_LONG) ? fs_rise_i
                                                    : (armed_q & bclk_rise_i));
  assign shift_o = active_q & bclk_rise_i & ~at_last;
  assign end_o   = active_q & bclk_rise_i & at_last;
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      last_q   <= '0;
    end else if (start_o) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      last_q   <= slot16_i ? CNT_W'(SLOT_LONG - 1) : CNT_W'(SLOT_SHORT - 1);
    end else if (end_o) begin
      active_q <= 1'b0;
    end else if (shift_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // short-frame: sync seen high at a falling edge arms the next rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (fmt_i == FMT_LONG || start_o) begin
      armed_q <= 1'b0;
    end else if (!active_q && bclk_fall_i && fs_level_i) begin
      armed_q <= 1'b1;
    end
  end

  // R5: bit index never passes the latched slot end
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q <= last_q));

  // R10, R11: an open slot keeps running with its latched length
  a_r11_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !end_o) |=> (active_q && $stable(last_q)));

  // R5: slot closes only on a bit-clock rising edge
  a_r5_close_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> $past(bclk_rise_i));
endmodule

// File: rtl/pcm_shifter.sv
module pcm_shifter #(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned SLOT_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                shift_i,
  input  logic                clear_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                dx_o
);
  localparam int unsigned PAD_W = SLOT_W - SAMPLE_W;

  logic [SLOT_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= {sample_i, {PAD_W{1'b0}}};
    else if (clear_i) sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[SLOT_W-2:0], 1'b0};
  end

  assign dx_o = sr_q[SLOT_W-1];
endmodule

// File: rtl/pcm_slave_tx.sv
module pcm_slave_tx
  import pcm_tx_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = SAMPLE_W_DEF,
  parameter int unsigned SLOT_SHORT = SLOT_SHORT_DEF,
  parameter int unsigned SLOT_LONG  = SLOT_LONG_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                fsync_i,
  input  logic                cfg_long_i,
  input  logic                cfg_slot16_i,
  input  logic                s_valid_i,
  input  logic [SAMPLE_W-1:0] s_data_i,
  output logic                s_ready_o,
  output logic                dx_o,
  output logic                dx_oe_o
);
  logic bclk_lvl, bclk_prev, fs_lvl, fs_prev;
  logic bclk_rise, bclk_fall, fs_rise;
  logic start, shift, slot_end, active;
  logic [SAMPLE_W-1:0] next_sample;

  pcm_edge_sync #(.STAGES(SYNC_DEPTH)) i_bclk_sync (
    .clk_i, .rst_ni, .d_i(bclk_i), .level_o(bclk_lvl), .prev_o(bclk_prev)
  );
  pcm_edge_sync #(.STAGES(SYNC_DEPTH)) i_fs_sync (
    .clk_i, .rst_ni, .d_i(fsync_i), .level_o(fs_lvl), .prev_o(fs_prev)
  );

  assign bclk_rise = bclk_lvl & ~bclk_prev;
  assign bclk_fall = ~bclk_lvl & bclk_prev;
  assign fs_rise   = fs_lvl & ~fs_prev;

  pcm_frame_ctrl #(.SLOT_SHORT(SLOT_SHORT), .SLOT_LONG(SLOT_LONG)) i_ctrl (
    .clk_i, .rst_ni,
    .bclk_rise_i(bclk_rise), .bclk_fall_i(bclk_fall),
    .fs_level_i(fs_lvl), .fs_rise_i(fs_rise),
    .fmt_i(sync_fmt_e'(cfg_long_i)), .slot16_i(cfg_slot16_i),
    .start_o(start), .shift_o(shift), .end_o(slot_end), .active_o(active)
  );

  pcm_sample_buf #(.SAMPLE_W(SAMPLE_W)) i_buf (
    .clk_i, .rst_ni, .s_valid_i, .s_data_i, .s_ready_o,
    .take_i(start), .next_o(next_sample)
  );

  pcm_shifter #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_LONG)) i_shift (
    .clk_i, .rst_ni, .load_i(start), .shift_i(shift), .clear_i(slot_end),
    .sample_i(next_sample), .dx_o
  );

  assign dx_oe_o = active;

  // R6: line quiet while released
  a_r6_dx_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dx_oe_o |-> !dx_o);

  // R4: first slot bit is the sample MSB
  a_r4_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (dx_oe_o && dx_o == $past(next_sample[SAMPLE_W-1])));
endmodule

// File: tb/test_pcm_slave_tx.sv
module test_pcm_slave_tx;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, cfg_long = 1'b0, cfg_slot16 = 1'b0;
  logic s_valid = 1'b0;
  logic [9:0] s_data = '0;
  logic s_ready, dx, dx_oe;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [9:0] m_hold = '0, m_last = '0;
  bit m_full = 1'b0;

  always #5 clk = ~clk;

  pcm_slave_tx i_pcm_slave_tx (
    .clk_i(clk), .rst_ni, .bclk_i(bclk), .fsync_i(fsync),
    .cfg_long_i(cfg_long), .cfg_slot16_i(cfg_slot16),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
    .dx_o(dx), .dx_oe_o(dx_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] v);
    @(negedge clk);
    check(s_ready == 1'b1, "R7 ready before push", s_ready, 1);
    s_valid = 1'b1; s_data = v;
    @(negedge clk);
    s_valid = 1'b0;
    m_hold = v; m_full = 1'b1;
    check(s_ready == 1'b0, "R7 ready after push", s_ready, 0);
  endtask

  // one frame of 20 bit periods; expected values from the requirements
  task automatic run_frame(input bit lng, input bit s16, input int fs_len,
                           input bit glitch, input bit flip, input bit mid_push,
                           input logic [9:0] mid_val, input bit pre_push,
                           input logic [9:0] pre_val, input bit blocked,
                           input string ftag);
    logic [9:0] smp;
    int slot;
    cfg_long = lng; cfg_slot16 = s16;
    if (pre_push && !m_full) push(pre_val);
    if (blocked) begin
      // R7: offer while full must be refused
      @(negedge clk);
      s_valid = 1'b1; s_data = ~m_hold;
      repeat (2) @(negedge clk);
      s_valid = 1'b0;
      check(s_ready == 1'b0, "R7 refused while full", s_ready, 0);
    end
    smp = m_full ? m_hold : m_last;
    m_full = 1'b0; m_last = smp;
    slot = s16 ? 16 : 13;
    for (int k = 0; k < 20; k++) begin
      int idx;
      bit exp_oe, exp_dx;
      string tag;
      @(negedge clk);
      bclk = 1'b1;
      if (lng) fsync = (k < fs_len) && !(glitch && k >= 3 && k < 5);
      else     fsync = (k == 0);
      repeat (4) @(negedge clk);
      idx = lng ? k : k - 1;
      exp_oe = (idx >= 0) && (idx < slot);
      exp_dx = exp_oe && (idx < 10) && smp[9 - idx];
      if (ftag != "")        tag = ftag;
      else if (!exp_oe)      tag = "R5 idle";
      else if (idx >= 10)    tag = "R4 padding";
      else                   tag = lng ? "R3 long data" : "R2 short data";
      check({dx_oe, dx} == {exp_oe, exp_dx}, tag, {dx_oe, dx}, {exp_oe, exp_dx});
      if (!exp_oe) check(dx == 1'b0, "R6 quiet line", dx, 0);
      bclk = 1'b0;
      if (flip && k == 5) cfg_slot16 = ~s16;
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        if (mid_push && k == 4 && j == 0) begin
          check(s_ready == 1'b1, "R9 ready in slot", s_ready, 1);
          s_valid = 1'b1; s_data = mid_val;
        end else if (mid_push && k == 4 && j == 1) begin
          s_valid = 1'b0; m_hold = mid_val; m_full = 1'b1;
        end
      end
    end
    cfg_slot16 = s16;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check({dx_oe, dx, s_ready} == 3'b001, "R1 reset state", {dx_oe, dx, s_ready}, 1);

    // directed corners
    run_frame(1'b0, 1'b0, 1, 1'b0, 1'b0, 1'b0, '0, 1'b1, 10'h3A5, 1'b0, "R2 short 13");
    run_frame(1'b0, 1'b1, 1, 1'b0, 1'b0, 1'b0, '0, 1'b1, 10'h2CB, 1'b0, "R4 short 16");
    run_frame(1'b1, 1'b0, 8, 1'b0, 1'b0, 1'b0, '0, 1'b1, 10'h1F0, 1'b0, "R3 long 13");
    run_frame(1'b1, 1'b1, 19, 1'b0, 1'b0, 1'b0, '0, 1'b1, 10'h3FF, 1'b0, "R5 long sync held");
    run_frame(1'b1, 1'b1, 12, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, "R8 repeat");
    run_frame(1'b1, 1'b1, 10, 1'b0, 1'b0, 1'b1, 10'h155, 1'b1, 10'h2AA, 1'b0, "R9 mid push");
    run_frame(1'b0, 1'b0, 1, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, "R9 next frame");
    run_frame(1'b1, 1'b1, 9, 1'b1, 1'b0, 1'b0, '0, 1'b1, 10'h201, 1'b0, "R11 resync ignored");
    run_frame(1'b1, 1'b1, 6, 1'b0, 1'b1, 1'b0, '0, 1'b1, 10'h0C3, 1'b0, "R10 cfg flip");
    run_frame(1'b0, 1'b1, 1, 1'b0, 1'b1, 1'b0, '0, 1'b1, 10'h333, 1'b0, "R10 cfg flip short");
    run_frame(1'b0, 1'b0, 1, 1'b0, 1'b0, 1'b0, '0, 1'b1, 10'h0F0, 1'b1, "R7 blocked offer");

    for (int f = 0; f < 30; f++) begin
      bit lng, s16, pre, mid;
      lng = 1'($urandom % 2);
      s16 = 1'($urandom % 2);
      pre = ($urandom % 4) != 0;
      mid = ($urandom % 3) == 0;
      run_frame(lng, s16, 1 + int'($urandom % 19), 1'b0, 1'b0, mid,
                10'($urandom), pre, 10'($urandom), 1'b0, "");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule